// File: doc/BRIEF.md
# Weighted Output Port Selector

This unit is the selection stage of an adaptive, fault-tolerant mesh router. The routing function has already worked out which output directions may carry the packet at the head of an input buffer. This unit receives that set of directions as a candidate mask. For each direction it also receives two values:

- a fault-aware path-diversity figure, which says how many usable routes remain beyond that port;
- the number of free slots in the downstream input buffer.

The unit multiplies the two values for each direction. The product rates how readily the port will drain traffic. The unit then picks the port with the largest product among the candidates that are not held by another packet's wormhole.

A port held by another packet's wormhole is marked in a reservation vector and is never picked. If only one candidate is free, that port is taken at once, even when a held port scores higher. If no candidate is free, the valid flag stays low and the head flit stalls. The selection is evaluated again on the next clock with whatever mask and reservation state is then presented.

The result is a registered one-hot grant with a valid flag, one clock after the inputs. Dividing each score by the sum of the candidates' diversity values would not change the ranking, so the unit leaves it out.

Top module: `ebl_out_sel`

## Requirements
- R1: A direction's score is its diversity value times its free-slot count, as an unsigned product. Among the available candidates, the one with the strictly largest score is granted.
- R2: A direction whose reservation bit is set is never granted, whatever its score.
- R3: When no candidate is available, the valid flag is low and the grant is all zero. The next cycle evaluates the inputs afresh, so a port freed in that cycle can be granted.
- R4: When exactly one candidate is available, it is granted. This holds even if a reserved candidate scores higher, and even if the free candidate's score is zero.
- R5: Equal top scores go to the earliest port in the order East, West, North, South. In every 4-bit vector, bit 0 is East, bit 1 West, bit 2 North and bit 3 South. Lane k of the packed diversity and free-slot inputs belongs to the port of bit k. The grant is one-hot whenever the valid flag is high.
- R6: A direction outside the candidate mask is never granted, whatever its score.
- R7: While no request is presented, the valid flag is low on the following cycle.
- R8: While reset is asserted, the grant is zero and the valid flag is low.
- R9: The grant and valid flag reflect the inputs sampled at the previous rising clock edge.
- R10: Free-slot counts span 0 to the buffer depth (default 4). The largest product (63 × 4 = 252 with default widths) is compared without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | A head flit is waiting for selection |
| cand_i | input | 4 | Candidate mask from the routing function |
| resv_i | input | 4 | Port held by another packet's wormhole |
| pd_i | input | 4*PD_W | Per-port fault-aware diversity, lane k for port k |
| free_i | input | 4*FREE_W | Per-port downstream free slots, lane k for port k |
| grant_o | output | 4 | One-hot selected port |
| grant_vld_o | output | 1 | A port was selected |

## Verification
The bench builds the unit with its defaults: a 6-bit diversity value and a buffer depth of 4, which makes the free-slot field 3 bits wide. These widths let the vectors reach the largest product of 252 next to close runners-up such as 248. They also cover a case where a smaller diversity value wins on a larger slot count (64 against 63), which a ranking by diversity alone would get wrong. With four lanes, the bench can set up exact two-way ties between any pair of ports, reserved ports that score higher than the only free port, and a stall that clears on the very next cycle.

// File: rtl/ebl_sel_pkg.sv
package ebl_sel_pkg;
  localparam int unsigned NPORT = 4;
  localparam int unsigned IDX_W = $clog2(NPORT);

  typedef enum logic [IDX_W-1:0] {
    PORT_E = 2'd0,
    PORT_W = 2'd1,
    PORT_N = 2'd2,
    PORT_S = 2'd3
  } port_e;
endpackage

// File: rtl/ebl_score.sv
module ebl_score #(
  parameter int unsigned NPORT  = 4,
  parameter int unsigned PD_W   = 6,
  parameter int unsigned FREE_W = 3,
  localparam int unsigned SCORE_W = PD_W + FREE_W
) (
  input  logic [NPORT*PD_W-1:0]    pd_i,
  input  logic [NPORT*FREE_W-1:0]  free_i,
  output logic [NPORT*SCORE_W-1:0] score_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [SCORE_W-1:0] pd_ext, free_ext;
    assign pd_ext   = SCORE_W'(pd_i[p*PD_W +: PD_W]);
    assign free_ext = SCORE_W'(free_i[p*FREE_W +: FREE_W]);
    assign score_o[p*SCORE_W +: SCORE_W] = pd_ext * free_ext;
  end
endmodule

// File: rtl/ebl_pick.sv
module ebl_pick #(
  parameter int unsigned NPORT   = 4,
  parameter int unsigned SCORE_W = 9
) (
  input  logic [NPORT-1:0]         avail_i,
  input  logic [NPORT*SCORE_W-1:0] score_i,
  output logic [NPORT-1:0]         pick_o
);
  logic [SCORE_W-1:0] best;
  logic               found;

  // Lower index wins ties: strict compare keeps the earlier port.
  always_comb begin
    pick_o = '0;
    best   = '0;
    found  = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (avail_i[p] && (!found || score_i[p*SCORE_W +: SCORE_W] > best)) begin
        pick_o = '0;
        pick_o[p] = 1'b1;
        best   = score_i[p*SCORE_W +: SCORE_W];
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ebl_out_sel.sv
module ebl_out_sel
  import ebl_sel_pkg::*;
#(
  parameter int unsigned PD_W      = 6,
  parameter int unsigned BUF_DEPTH = 4,
  localparam int unsigned FREE_W   = $clog2(BUF_DEPTH + 1),
  localparam int unsigned SCORE_W  = PD_W + FREE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [NPORT-1:0]        cand_i,
  input  logic [NPORT-1:0]        resv_i,
  input  logic [NPORT*PD_W-1:0]   pd_i,
  input  logic [NPORT*FREE_W-1:0] free_i,
  output logic [NPORT-1:0]        grant_o,
  output logic                    grant_vld_o
);
  logic [NPORT*SCORE_W-1:0] score;
  logic [NPORT-1:0]         avail, pick;

  assign avail = req_i ? (cand_i & ~resv_i) : '0;

  ebl_score #(.NPORT(NPORT), .PD_W(PD_W), .FREE_W(FREE_W)) u_score (
    .pd_i   (pd_i),
    .free_i (free_i),
    .score_o(score)
  );

  ebl_pick #(.NPORT(NPORT), .SCORE_W(SCORE_W)) u_pick (
    .avail_i(avail),
    .score_i(score),
    .pick_o (pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o     <= '0;
      grant_vld_o <= 1'b0;
    end else begin
      grant_o     <= pick;
      grant_vld_o <= |avail;
    end
  end
endmodule

// File: rtl/ebl_out_sel_chk.sv
module ebl_out_sel_chk #(
  parameter int unsigned NPORT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [NPORT-1:0] cand_i,
  input logic [NPORT-1:0] resv_i,
  input logic [NPORT-1:0] grant_o,
  input logic             grant_vld_o
);
  assert_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> ($countones(grant_o) == 1));

  assert_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_vld_o |-> (grant_o == '0));

  assert_no_reserved_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((grant_o & $past(resv_i)) == '0));

  assert_cand_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((grant_o & ~$past(cand_i)) == '0));

  assert_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cand_i & ~resv_i) == '0) |=> !grant_vld_o);

  assert_lone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && $countones(cand_i & ~resv_i) == 1) |=> (grant_o == $past(cand_i & ~resv_i)));

  assert_no_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !grant_vld_o);
endmodule

bind ebl_out_sel ebl_out_sel_chk #(.NPORT(4)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .cand_i     (cand_i),
  .resv_i     (resv_i),
  .grant_o    (grant_o),
  .grant_vld_o(grant_vld_o)
);

// File: tb/ebl_out_sel_test.sv
`timescale 1ns/1ps
module ebl_out_sel_test;
  localparam int PD_W = 6;
  localparam int FR_W = 3;

  typedef struct packed {
    logic            req;
    logic [3:0]      cand;
    logic [3:0]      resv;
    logic [4*PD_W-1:0] pd;
    logic [4*FR_W-1:0] fr;
    logic            vld;
    logic [3:0]      gnt;
  } vec_t;

  function automatic logic [4*PD_W-1:0] p4(int e, int w, int n, int s);
    return {PD_W'(s), PD_W'(n), PD_W'(w), PD_W'(e)};
  endfunction
  function automatic logic [4*FR_W-1:0] f4(int e, int w, int n, int s);
    return {FR_W'(s), FR_W'(n), FR_W'(w), FR_W'(e)};
  endfunction

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R1: E 40 vs S 20
    '{1'b1, 4'b1001, 4'b0000, p4(10,0,0,20), f4(4,0,0,1), 1'b1, 4'b0001},
    // R1: E 10 vs S 80
    '{1'b1, 4'b1001, 4'b0000, p4(10,0,0,20), f4(1,0,0,4), 1'b1, 4'b1000},
    // R5: four-way tie goes East
    '{1'b1, 4'b1111, 4'b0000, p4(5,5,5,5),   f4(2,2,2,2), 1'b1, 4'b0001},
    // R5: W 12 ties N 12, West first
    '{1'b1, 4'b0110, 4'b0000, p4(0,3,4,0),   f4(0,4,3,0), 1'b1, 4'b0010},
    // R2/R4: E reserved with higher score, S lone
    '{1'b1, 4'b1001, 4'b0001, p4(60,0,0,1),  f4(4,0,0,1), 1'b1, 4'b1000},
    // R3: all candidates reserved
    '{1'b1, 4'b0011, 4'b0011, p4(9,9,0,0),   f4(4,4,0,0), 1'b0, 4'b0000},
    // R3: empty mask
    '{1'b1, 4'b0000, 4'b0000, p4(9,9,9,9),   f4(4,4,4,4), 1'b0, 4'b0000},
    // R7: no request
    '{1'b0, 4'b1111, 4'b0000, p4(9,9,9,9),   f4(4,4,4,4), 1'b0, 4'b0000},
    // R6: E outscores but is not a candidate
    '{1'b1, 4'b0100, 4'b0000, p4(63,0,1,0),  f4(4,0,1,0), 1'b1, 4'b0100},
    // R10: N 252 vs S 248
    '{1'b1, 4'b1100, 4'b0000, p4(0,0,63,62), f4(0,0,4,4), 1'b1, 4'b0100},
    // R4: lone candidate with zero free slots
    '{1'b1, 4'b1000, 4'b0000, p4(0,0,0,7),   f4(0,0,0,0), 1'b1, 4'b1000},
    // R1: W 64 beats E 63 despite lower diversity
    '{1'b1, 4'b0011, 4'b0000, p4(63,16,0,0), f4(1,4,0,0), 1'b1, 4'b0010}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [3:0] cand_i = '0, resv_i = '0;
  logic [4*PD_W-1:0] pd_i = '0;
  logic [4*FR_W-1:0] free_i = '0;
  logic [3:0] grant_o;
  logic grant_vld_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk_i = ~clk_i;

  ebl_out_sel uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .cand_i(cand_i),
    .resv_i(resv_i), .pd_i(pd_i), .free_i(free_i),
    .grant_o(grant_o), .grant_vld_o(grant_vld_o)
  );

  task automatic check(string tag, logic ev, logic [3:0] eg);
    n_chk++;
    if (grant_vld_o !== ev || grant_o !== eg) begin
      n_bad++;
      $display("FAIL %s: got vld=%b grant=%b expected vld=%b grant=%b",
               tag, grant_vld_o, grant_o, ev, eg);
    end
  endtask

  task automatic apply(logic r, logic [3:0] c, logic [3:0] rs,
                       logic [4*PD_W-1:0] p, logic [4*FR_W-1:0] f);
    @(negedge clk_i);
    req_i = r; cand_i = c; resv_i = rs; pd_i = p; free_i = f;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R8: reset state, with a live request driven during reset
    req_i = 1'b1; cand_i = 4'b1111; pd_i = p4(5,5,5,5); free_i = f4(4,4,4,4);
    repeat (3) @(negedge clk_i);
    check("R8 reset", 1'b0, 4'b0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].req, VECS[i].cand, VECS[i].resv, VECS[i].pd, VECS[i].fr);
      check($sformatf("R1/R9 vector %0d", i), VECS[i].vld, VECS[i].gnt);
    end

    // R3/R9: stall, then the port is released and granted on the next cycle
    apply(1'b1, 4'b0100, 4'b0100, p4(0,0,8,0), f4(0,0,2,0));
    check("R3 stall", 1'b0, 4'b0000);
    apply(1'b1, 4'b0100, 4'b0000, p4(0,0,8,0), f4(0,0,2,0));
    check("R3 retry", 1'b1, 4'b0100);

    // R9: exactly one cycle of latency
    @(negedge clk_i);
    cand_i = 4'b0010; pd_i = p4(0,3,0,0); free_i = f4(0,1,0,0);
    #1 check("R9 before edge", 1'b1, 4'b0100);
    @(negedge clk_i);
    check("R9 after edge", 1'b1, 4'b0010);

    // R2: reserved port with the top score among three
    apply(1'b1, 4'b1110, 4'b0100, p4(0,2,60,3), f4(0,4,4,4));
    check("R2 reserved top", 1'b1, 4'b1000);

    // R8: reset asserted mid-run clears outputs
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check("R8 async reset", 1'b0, 4'b0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule